// File: doc/BRIEF.md
# Floating-Point Condition-Code Test Unit

This unit turns an 8-bit vector of floating-point condition flags into two kinds of result. The first is a branch decision. A branch-test operation selects a group of 1, 2 or 4 adjacent flags, starting at a 3-bit index. In true sense it reports whether any selected flag is set. In false sense it reports whether any selected flag is clear.

The second kind is a conditional move on two 32-bit lanes. Each lane of the result is either the source lane or the old destination lane. The choice comes from condition flags or from an integer control word. Paired moves pick each lane from consecutive flags starting at the index. Integer-controlled moves copy when the control word is zero, or when it is nonzero.

Decoding is combinational. One registered output stage captures the result on each cycle that `in_valid` is high and holds it otherwise.

Top module: `fcc_test_unit`

## Requirements
- R1: While reset is asserted, and until the first valid operation after it, `out_valid`, `br_taken`, `res_lo` and `res_hi` are all 0.
- R2: With `grp_sel` = 2'b00, a true-sense branch test (`op` = 4'h0) gives `cc_vec[cc_idx]`, and a false-sense test (`op` = 4'h1) gives its inverse.
- R3: With `grp_sel` = 2'b01, the test covers flags `cc_idx` and `cc_idx`+1. True sense gives 1 when any covered flag is 1. False sense gives 1 when any covered flag is 0.
- R4: With `grp_sel` = 2'b10 or 2'b11, the test covers four flags, `cc_idx` through `cc_idx`+3, with the same any-set and any-clear rules as R3.
- R5: In a group test, flag positions above 7 count as 0 for true sense and as 1 for false sense. They therefore never make the result 1.
- R6: A paired move (`op` 4'h4 = move on true, 4'h5 = move on false) controls the lower lane by flag `cc_idx` and the upper lane by flag `cc_idx`+1. Flag position 8 reads as 0. A lane takes its source only when its flag is 1 (on true) or 0 (on false). Otherwise it keeps its destination value.
- R7: A scalar flag move (`op` 4'h2 = on true, 4'h3 = on false) controls the lower lane by flag `cc_idx`. The upper lane always carries `dst_hi`.
- R8: Integer moves copy the source when `int_ctl` is zero (`op` 4'h6 scalar, 4'h8 paired) or nonzero (`op` 4'h7 scalar, 4'h9 paired). Paired forms move both lanes together. Scalar forms move only the lower lane and pass `dst_hi` through.
- R9: Results appear one clock after the cycle in which `in_valid` is high. `out_valid` is `in_valid` delayed by one clock.
- R10: In a cycle where `in_valid` is low, `br_taken`, `res_lo` and `res_hi` keep their values, whatever the other inputs do.
- R11: Move operations give `br_taken` = 0. Branch operations and unassigned op codes (4'hA to 4'hF) return the destination lanes unchanged. Unassigned codes also give `br_taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present; enables the output register |
| op | input | 4 | Operation code |
| cc_vec | input | 8 | Condition flag vector |
| cc_idx | input | 3 | Index of the first flag used |
| grp_sel | input | 2 | Branch group size: 00 one, 01 two, 1x four |
| int_ctl | input | 32 | Integer control word for zero/nonzero moves |
| src_lo | input | 32 | Source, lower lane |
| src_hi | input | 32 | Source, upper lane |
| dst_lo | input | 32 | Old destination, lower lane |
| dst_hi | input | 32 | Old destination, upper lane |
| out_valid | output | 1 | Registered result valid |
| br_taken | output | 1 | Registered branch decision |
| res_lo | output | 32 | Registered result, lower lane |
| res_hi | output | 32 | Registered result, upper lane |

## Verification
The single-flag test walks every index over alternating and sparse flag vectors. This separates an off-by-one index from a wrong sense inversion. The group tests use vectors with one isolated set bit, or one isolated clear bit, placed just inside and just outside each window. Those patterns tell whether the mask width is right and whether the window edge is handled. Indices 5 to 7 with four-flag groups, and index 7 with paired moves, show how out-of-range positions are treated in each sense. Move patterns with differing flag pairs confirm that the two lanes choose independently, while zero and nonzero integer words confirm lock-step lane movement.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_BR_T   = 4'h0;
  localparam logic [OP_W-1:0] OP_BR_F   = 4'h1;
  localparam logic [OP_W-1:0] OP_MVT_S  = 4'h2;
  localparam logic [OP_W-1:0] OP_MVF_S  = 4'h3;
  localparam logic [OP_W-1:0] OP_MVT_P  = 4'h4;
  localparam logic [OP_W-1:0] OP_MVF_P  = 4'h5;
  localparam logic [OP_W-1:0] OP_MVZ_S  = 4'h6;
  localparam logic [OP_W-1:0] OP_MVN_S  = 4'h7;
  localparam logic [OP_W-1:0] OP_MVZ_P  = 4'h8;
  localparam logic [OP_W-1:0] OP_MVN_P  = 4'h9;

  typedef enum logic [1:0] {
    GRP_ONE  = 2'b00,
    GRP_TWO  = 2'b01,
    GRP_FOUR = 2'b10,
    GRP_FOUR_ALT = 2'b11
  } fcc_grp_e;
endpackage

// File: rtl/fcc_branch_eval.sv
module fcc_branch_eval
  import fcc_pkg::*;
#(
  parameter int CC_W  = 8,
  parameter int IDX_W = $clog2(CC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CC_W-1:0]  cc,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       grp,
  input  logic             sense_true,
  output logic             taken
);
  localparam int EXT_W = CC_W + 4;

  logic [EXT_W-1:0] base_mask;
  logic [EXT_W-1:0] wide_mask;
  logic [CC_W-1:0]  win_mask;

  always_comb begin
    case (grp)
      GRP_ONE: base_mask = EXT_W'(1);
      GRP_TWO: base_mask = EXT_W'(3);
      default: base_mask = EXT_W'(15);
    endcase
  end

  // positions past the top flag fall off the window: they never contribute
  assign wide_mask = base_mask << idx;
  assign win_mask  = wide_mask[CC_W-1:0];

  always_comb begin
    if (sense_true) taken = |(cc & win_mask);
    else            taken = |(~cc & win_mask);
  end

  assert_single_bit_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_ONE) |-> (taken == (sense_true ? cc[idx] : !cc[idx])));

  assert_all_set_false_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    ((&cc) && !sense_true) |-> !taken);

  assert_top_edge_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (sense_true && grp[1] && idx == IDX_W'(CC_W-1)) |-> (taken == cc[CC_W-1]));
endmodule

// File: rtl/fcc_lane_select.sv
module fcc_lane_select #(
  parameter int LANE_W = 32,
  parameter int NLANES = 2,
  localparam int BUS_W = LANE_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] lane_en,
  input  logic [BUS_W-1:0]  src,
  input  logic [BUS_W-1:0]  dst,
  output logic [BUS_W-1:0]  res
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_comb begin
      if (lane_en[g]) res[g*LANE_W +: LANE_W] = src[g*LANE_W +: LANE_W];
      else            res[g*LANE_W +: LANE_W] = dst[g*LANE_W +: LANE_W];
    end

    assert_lane_keep_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[g] |-> (res[g*LANE_W +: LANE_W] == dst[g*LANE_W +: LANE_W]));
    assert_lane_take_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[g] |-> (res[g*LANE_W +: LANE_W] == src[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/fcc_out_reg.sv
module fcc_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              d_taken,
  input  logic [DATA_W-1:0] d_res,
  output logic              out_valid,
  output logic              q_taken,
  output logic [DATA_W-1:0] q_res
);
  logic rst_s1, rst_q;
  logic              vld_nxt, tkn_nxt;
  logic [DATA_W-1:0] res_nxt;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  always_comb begin
    vld_nxt = in_valid;
    tkn_nxt = q_taken;
    res_nxt = q_res;
    if (in_valid) begin
      tkn_nxt = d_taken;
      res_nxt = d_res;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      q_taken   <= 1'b0;
      q_res     <= '0;
    end else begin
      out_valid <= vld_nxt;
      q_taken   <= tkn_nxt;
      q_res     <= res_nxt;
    end
  end

  assert_valid_rise_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  assert_valid_low_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);
  assert_hold_idle_R10 : assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(q_taken) && $stable(q_res)));
endmodule

// File: rtl/fcc_test_unit.sv
module fcc_test_unit
  import fcc_pkg::*;
#(
  parameter int CC_W   = 8,
  parameter int LANE_W = 32,
  parameter int INT_W  = 32,
  localparam int IDX_W  = $clog2(CC_W),
  localparam int NLANES = 2,
  localparam int BUS_W  = LANE_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [CC_W-1:0]   cc_vec,
  input  logic [IDX_W-1:0]  cc_idx,
  input  logic [1:0]        grp_sel,
  input  logic [INT_W-1:0]  int_ctl,
  input  logic [LANE_W-1:0] src_lo,
  input  logic [LANE_W-1:0] src_hi,
  input  logic [LANE_W-1:0] dst_lo,
  input  logic [LANE_W-1:0] dst_hi,
  output logic              out_valid,
  output logic              br_taken,
  output logic [LANE_W-1:0] res_lo,
  output logic [LANE_W-1:0] res_hi
);
  logic              is_branch, sense_true, raw_taken, gated_taken;
  logic [CC_W-1:0]   cc_shift;
  logic              flag_lo, flag_hi, int_zero;
  logic [NLANES-1:0] lane_en;
  logic [BUS_W-1:0]  lane_res, q_res;

  assign is_branch  = (op == OP_BR_T) || (op == OP_BR_F);
  assign sense_true = (op == OP_BR_T);

  fcc_branch_eval #(.CC_W(CC_W), .IDX_W(IDX_W)) u_branch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cc         (cc_vec),
    .idx        (cc_idx),
    .grp        (grp_sel),
    .sense_true (sense_true),
    .taken      (raw_taken)
  );

  assign gated_taken = is_branch & raw_taken;

  // zero-fill shift: the flag above the top reads as 0
  assign cc_shift = cc_vec >> cc_idx;
  assign flag_lo  = cc_shift[0];
  assign flag_hi  = cc_shift[1];
  assign int_zero = (int_ctl == '0);

  always_comb begin
    case (op)
      OP_MVT_S: lane_en = {1'b0, flag_lo};
      OP_MVF_S: lane_en = {1'b0, ~flag_lo};
      OP_MVT_P: lane_en = {flag_hi, flag_lo};
      OP_MVF_P: lane_en = {~flag_hi, ~flag_lo};
      OP_MVZ_S: lane_en = {1'b0, int_zero};
      OP_MVN_S: lane_en = {1'b0, ~int_zero};
      OP_MVZ_P: lane_en = {int_zero, int_zero};
      OP_MVN_P: lane_en = {~int_zero, ~int_zero};
      default:  lane_en = '0;
    endcase
  end

  fcc_lane_select #(.LANE_W(LANE_W), .NLANES(NLANES)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_en (lane_en),
    .src     ({src_hi, src_lo}),
    .dst     ({dst_hi, dst_lo}),
    .res     (lane_res)
  );

  fcc_out_reg #(.DATA_W(BUS_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d_taken   (gated_taken),
    .d_res     (lane_res),
    .out_valid (out_valid),
    .q_taken   (br_taken),
    .q_res     (q_res)
  );

  assign res_lo = q_res[LANE_W-1:0];
  assign res_hi = q_res[BUS_W-1:LANE_W];

  assert_no_move_enable_on_branch_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> (lane_en == '0));
  assert_scalar_upper_keep_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MVT_S || op == OP_MVF_S || op == OP_MVZ_S || op == OP_MVN_S) |-> !lane_en[1]);
  assert_int_pair_lockstep_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MVZ_P || op == OP_MVN_P) |-> (lane_en[0] == lane_en[1]));
endmodule

// File: tb/tb_fcc_test_unit.sv
`timescale 1ns/1ps
module tb_fcc_test_unit;
  logic        clk, rst_n, in_valid;
  logic [3:0]  op;
  logic [7:0]  cc_vec;
  logic [2:0]  cc_idx;
  logic [1:0]  grp_sel;
  logic [31:0] int_ctl, src_lo, src_hi, dst_lo, dst_hi;
  logic        out_valid, br_taken;
  logic [31:0] res_lo, res_hi;

  int vectors = 0;
  int miscompares = 0;

  fcc_test_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cc_vec(cc_vec),
    .cc_idx(cc_idx), .grp_sel(grp_sel), .int_ctl(int_ctl), .src_lo(src_lo),
    .src_hi(src_hi), .dst_lo(dst_lo), .dst_hi(dst_hi), .out_valid(out_valid),
    .br_taken(br_taken), .res_lo(res_lo), .res_hi(res_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected branch decision, from the group rules
  function automatic logic ref_taken(input logic [3:0] o, input logic [7:0] c,
                                     input int idx, input logic [1:0] g);
    int n;
    logic hit;
    if (o != 4'h0 && o != 4'h1) return 1'b0;
    n = (g == 2'b00) ? 1 : (g == 2'b01) ? 2 : 4;
    hit = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (idx + k <= 7) begin
        if (o == 4'h0 && c[idx+k] == 1'b1) hit = 1'b1;
        if (o == 4'h1 && c[idx+k] == 1'b0) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  // expected lanes {hi, lo}
  function automatic logic [63:0] ref_res(input logic [3:0] o, input logic [7:0] c,
      input int idx, input logic [31:0] ic, input logic [31:0] sl, input logic [31:0] sh,
      input logic [31:0] dl, input logic [31:0] dh);
    logic b0, b1, iz, el, eh;
    b0 = c[idx];
    b1 = (idx < 7) ? c[idx+1] : 1'b0;
    iz = (ic == 32'd0);
    el = 1'b0; eh = 1'b0;
    case (o)
      4'h2: el = b0;
      4'h3: el = !b0;
      4'h4: begin el = b0;  eh = b1;  end
      4'h5: begin el = !b0; eh = !b1; end
      4'h6: el = iz;
      4'h7: el = !iz;
      4'h8: begin el = iz;  eh = iz;  end
      4'h9: begin el = !iz; eh = !iz; end
      default: ;
    endcase
    return {eh ? sh : dh, el ? sl : dl};
  endfunction

  task automatic run_op(input string req, input logic [3:0] o, input logic [7:0] c,
      input int idx, input logic [1:0] g, input logic [31:0] ic,
      input logic [31:0] sl, input logic [31:0] sh, input logic [31:0] dl, input logic [31:0] dh);
    @(negedge clk);
    in_valid = 1'b1; op = o; cc_vec = c; cc_idx = 3'(idx); grp_sel = g;
    int_ctl = ic; src_lo = sl; src_hi = sh; dst_lo = dl; dst_hi = dh;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {63'd0, br_taken}, {63'd0, ref_taken(o, c, idx, g)});
    check(req, {res_hi, res_lo}, ref_res(o, c, idx, ic, sl, sh, dl, dh));
  endtask

  task automatic t_reset_R1;
    check("R1", {61'd0, out_valid, br_taken, |{res_lo, res_hi}}, 64'd0);
  endtask

  task automatic t_single_R2;
    for (int i = 0; i < 8; i++) begin
      run_op("R2", 4'h0, 8'hA5, i, 2'b00, 0, 0, 0, 32'h11, 32'h22);
      run_op("R2", 4'h1, 8'hA5, i, 2'b00, 0, 0, 0, 32'h11, 32'h22);
      run_op("R2", 4'h0, 8'h10, i, 2'b00, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_pair_R3;
    for (int i = 0; i < 7; i++) begin
      run_op("R3", 4'h0, 8'h08, i, 2'b01, 0, 0, 0, 0, 0);
      run_op("R3", 4'h1, 8'hF7, i, 2'b01, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_quad_R4;
    for (int i = 0; i < 5; i++) begin
      run_op("R4", 4'h0, 8'h01, i, 2'b10, 0, 0, 0, 0, 0);
      run_op("R4", 4'h0, 8'h80, i, 2'b11, 0, 0, 0, 0, 0);
      run_op("R4", 4'h1, 8'hEF, i, 2'b10, 0, 0, 0, 0, 0);
      run_op("R4", 4'h1, 8'hFF, i, 2'b10, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_edge_R5;
    run_op("R5", 4'h0, 8'h7F, 7, 2'b10, 0, 0, 0, 0, 0);
    run_op("R5", 4'h1, 8'h80, 7, 2'b10, 0, 0, 0, 0, 0);
    run_op("R5", 4'h1, 8'hC0, 6, 2'b10, 0, 0, 0, 0, 0);
    run_op("R5", 4'h1, 8'h80, 7, 2'b01, 0, 0, 0, 0, 0);
    run_op("R5", 4'h0, 8'h20, 5, 2'b10, 0, 0, 0, 0, 0);
    run_op("R5", 4'h1, 8'hDF, 5, 2'b11, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pair_move_R6;
    for (int i = 0; i < 8; i++) begin
      run_op("R6", 4'h4, 8'b0110_1001, i, 2'b00, 0, 32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 32'hDDDD0004);
      run_op("R6", 4'h5, 8'b0110_1001, i, 2'b00, 0, 32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 32'hDDDD0004);
    end
    run_op("R6", 4'h4, 8'hFF, 7, 2'b00, 0, 32'h1, 32'h2, 32'h3, 32'h4);
    run_op("R6", 4'h5, 8'h00, 7, 2'b00, 0, 32'h1, 32'h2, 32'h3, 32'h4);
  endtask

  task automatic t_scalar_move_R7;
    for (int i = 0; i < 8; i++) begin
      run_op("R7", 4'h2, 8'h5A, i, 2'b00, 0, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F, 32'hF0F0F0F0);
      run_op("R7", 4'h3, 8'h5A, i, 2'b00, 0, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F, 32'hF0F0F0F0);
    end
  endtask

  task automatic t_int_move_R8;
    logic [31:0] words [3] = '{32'd0, 32'd1, 32'h80000000};
    for (int w = 0; w < 3; w++) begin
      for (int o = 6; o <= 9; o++)
        run_op("R8", 4'(o), 8'hFF, 0, 2'b00, words[w], 32'h55, 32'h66, 32'h77, 32'h88);
    end
  endtask

  task automatic t_timing_R9;
    @(negedge clk);
    in_valid = 1'b1; op = 4'h0; cc_vec = 8'h01; cc_idx = 3'd0; grp_sel = 2'b00;
    check("R9", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {62'd0, out_valid, br_taken}, 64'd3);
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_hold_R10;
    run_op("R10", 4'h4, 8'h03, 0, 2'b00, 0, 32'hCAFE0001, 32'hCAFE0002, 32'h0, 32'h0);
    run_op("R10", 4'h0, 8'h01, 0, 2'b00, 0, 32'h0, 32'h0, 32'hCAFE0001, 32'hCAFE0002);
    @(negedge clk);
    op = 4'h5; cc_vec = 8'h00; int_ctl = 32'd0; src_lo = 32'h1; src_hi = 32'h2;
    dst_lo = 32'h3; dst_hi = 32'h4;
    @(negedge clk);
    check("R10", {63'd0, br_taken}, 64'd1);
    check("R10", {res_hi, res_lo}, {32'hCAFE0002, 32'hCAFE0001});
  endtask

  task automatic t_unused_R11;
    run_op("R11", 4'h1, 8'h00, 0, 2'b10, 0, 32'h1, 32'h2, 32'h3, 32'h4);
    run_op("R11", 4'h2, 8'hFF, 0, 2'b00, 0, 32'h1, 32'h2, 32'h3, 32'h4);
    for (int o = 10; o < 16; o++)
      run_op("R11", 4'(o), 8'hFF, 0, 2'b00, 0, 32'h1, 32'h2, 32'h3, 32'h4);
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; cc_vec = '0; cc_idx = '0; grp_sel = '0;
    int_ctl = '0; src_lo = '0; src_hi = '0; dst_lo = '0; dst_hi = '0;
    repeat (3) @(negedge clk);
    t_reset_R1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_R1;
    t_timing_R9;
    t_single_R2;
    t_pair_R3;
    t_quad_R4;
    t_edge_R5;
    t_pair_move_R6;
    t_scalar_move_R7;
    t_int_move_R8;
    t_hold_R10;
    t_unused_R11;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule